// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block collects the error events of a CAN-style controller into sticky flags that software can inspect, and records which protocol violations were behind a bus error. The bit-level protocol engine delivers single-cycle event pulses: bus error, overload frame sent, receive overrun, bus lock, bus-off entry and bus-off recovery. With a bus error pulse it also delivers a vector of protocol error codes. The transmit and receive error counts come in as plain inputs. The block itself raises the error-warning and error-passive events when either count crosses its threshold.

Software sees four byte-wide registers through a simple write port and a separate combinational read select. The event register and the code register clear only the bits that are written as 0. A bit written as 1 is left alone, so a flag that has already been handled can be cleared without losing one that arrived in the meantime. A mode bit in the code register decides whether successive bus errors accumulate codes or whether each one replaces them. An enable register masks the events, and the masked result drives one level-sensitive interrupt line.

All ports are plain control and status signals. The event inputs are one-cycle strobes with no back-pressure, and register writes always complete in one cycle.

Top module: `can_err_report`

## Requirements
- R1: After reset every register reads 0 and `err_irq` is low. Registers are selected as 0 = event flags, 1 = event enable, 2 = error code, 3 = interrupt status.
- R2: Event flags are sticky and appear in the register in the cycle after their pulse. The bit positions are 7 = bus lock, 6 = overload frame sent, 5 = receive overrun, 4 = bus-off recovery, 3 = bus-off entry, 2 = error passive, 1 = error warning, 0 = bus error.
- R3: A write to the event register clears exactly the flags whose written bit is 0. Flags written as 1 keep their value.
- R4: When an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R5: The error-warning flag is set once, when the larger of the two error counts first reaches 96. It fires again only after both counts have dropped below 96 and one of them reaches 96 again.
- R6: The error-passive flag is set once, when either error count first exceeds 127, with the same re-arming rule as R5.
- R7: A bus error pulse captures `err_codes` into code register bits 6..0. The bit positions are 0 = stuff, 1 = form, 2 = ACK, 3 = CRC, 4 = recessive bit error, 5 = dominant bit error, 6 = ACK delimiter. Writing 0 to a code bit clears it, and writing 1 leaves it unchanged.
- R8: Code register bit 7 is a read/write mode bit. When it is 1, captured codes are ORed with those already held. When it is 0, each bus error replaces bits 6..0 with only the new codes. The mode in force before the write applies in that cycle.
- R9: The enable register uses the event bit positions. Status bit 5 and `err_irq` are 1 exactly when some flag and its enable bit are both 1. All other status bits read 0.
- R10: `err_codes` has no effect when `ev_bus_err` is low.
- R11: Writes to the status register change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bus_err | input | 1 | Bus error pulse |
| err_codes | input | 7 | Protocol error codes, valid with ev_bus_err |
| ev_overload | input | 1 | Overload frame sent pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_bus_lock | input | 1 | Bus lock pulse |
| ev_busoff_enter | input | 1 | Bus-off entry pulse |
| ev_busoff_exit | input | 1 | Bus-off recovery pulse |
| tx_err_cnt | input | 8 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | 8 | Read data (combinational) |
| err_irq | output | 1 | Masked error interrupt |

## Verification
The hardest situation to reach is a hardware set that lands in exactly the cycle of a software clear. This covers both the flag case and the code case, where the mode bit changes in that same cycle. The bench drives event pulses, code vectors and register writes on one shared negative edge, so these collisions happen both in directed steps and repeatedly in a long randomized phase. The threshold re-arming is reached by walking the counts across 96 and 128 in both directions, with steps larger than one and with both counts above the limit at once.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int REG_W  = 8;
  localparam int CODE_W = 7;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CODE   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int EV_BUSERR   = 0;
  localparam int EV_WARN     = 1;
  localparam int EV_PASSIVE  = 2;
  localparam int EV_BOENTER  = 3;
  localparam int EV_BOEXIT   = 4;
  localparam int EV_OVERRUN  = 5;
  localparam int EV_OVERLOAD = 6;
  localparam int EV_LOCK     = 7;

  localparam int STAT_AGG  = 5;
  localparam int CODE_MODE = 7;
endpackage

// File: rtl/can_err_thresh.sv
module can_err_thresh #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             hit_pulse
);
  logic level, level_q;

  assign level     = (int'(cnt_a) >= LIMIT) || (int'(cnt_b) >= LIMIT);
  assign hit_pulse = level && !level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  // R5/R6: a crossing produces a single pulse
  a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |=> !hit_pulse);
endmodule

// File: rtl/can_err_flagreg.sv
module can_err_flagreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr_we) q_n = q & clr_keep;
    q_n = q_n | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  // R4: a same-cycle set survives any clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec)));
  // R2: without a write no flag falls
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((q & $past(q)) == $past(q)));
  // R3: only bits written 0 clear
  a_r3_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set_vec == '0) |=> (q == ($past(q) & $past(clr_keep))));
endmodule

// File: rtl/can_err_codereg.sv
module can_err_codereg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] codes,
  input  logic         wr,
  input  logic [W:0]   wdata,
  output logic [W-1:0] code,
  output logic         accumulate
);
  logic [W-1:0] kept, code_n;

  always_comb begin
    kept = wr ? (code & wdata[W-1:0]) : code;
    if (capture) code_n = accumulate ? (kept | codes) : codes;
    else         code_n = kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code       <= '0;
      accumulate <= 1'b0;
    end else begin
      code <= code_n;
      if (wr) accumulate <= wdata[W];
    end
  end

  // R8: replace mode holds only the newest codes
  a_r8_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !accumulate) |=> (code == $past(codes)));
  // R8: accumulate mode keeps every new code
  a_r8_accum: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && accumulate) |=> ((code & $past(codes)) == $past(codes)));
  // R10: no capture and no write leaves the codes untouched
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !wr) |=> $stable(code));
endmodule

// File: rtl/can_err_report.sv
module can_err_report
  import can_err_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIMIT  = 96,
  parameter int PASS_LIMIT  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_bus_err,
  input  logic [CODE_W-1:0] err_codes,
  input  logic              ev_overload,
  input  logic              ev_overrun,
  input  logic              ev_bus_lock,
  input  logic              ev_busoff_enter,
  input  logic              ev_busoff_exit,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              err_irq
);
  localparam int N_LIM = 2;
  localparam int LIMITS [N_LIM] = '{WARN_LIMIT, PASS_LIMIT};

  logic [N_LIM-1:0]  lim_hit;
  logic [REG_W-1:0]  ev_set, ev_flags, ev_en;
  logic [CODE_W-1:0] code_q;
  logic              code_acc;
  logic              wr_flags, wr_enable, wr_code;

  genvar gi;
  generate
    for (gi = 0; gi < N_LIM; gi++) begin : g_lim
      can_err_thresh #(.CNT_W(CNT_W), .LIMIT(LIMITS[gi])) u_thr (
        .clk(clk), .rst_n(rst_n),
        .cnt_a(tx_err_cnt), .cnt_b(rx_err_cnt),
        .hit_pulse(lim_hit[gi]));
    end
  endgenerate

  assign wr_flags  = wr_en && (wr_sel == SEL_FLAGS);
  assign wr_enable = wr_en && (wr_sel == SEL_ENABLE);
  assign wr_code   = wr_en && (wr_sel == SEL_CODE);

  always_comb begin
    ev_set              = '0;
    ev_set[EV_BUSERR]   = ev_bus_err;
    ev_set[EV_WARN]     = lim_hit[0];
    ev_set[EV_PASSIVE]  = lim_hit[1];
    ev_set[EV_BOENTER]  = ev_busoff_enter;
    ev_set[EV_BOEXIT]   = ev_busoff_exit;
    ev_set[EV_OVERRUN]  = ev_overrun;
    ev_set[EV_OVERLOAD] = ev_overload;
    ev_set[EV_LOCK]     = ev_bus_lock;
  end

  can_err_flagreg #(.W(REG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(ev_set),
    .clr_we(wr_flags), .clr_keep(wr_data), .q(ev_flags));

  can_err_codereg #(.W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .capture(ev_bus_err), .codes(err_codes),
    .wr(wr_code), .wdata(wr_data[CODE_W:0]),
    .code(code_q), .accumulate(code_acc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ev_en <= '0;
    else if (wr_enable) ev_en <= wr_data;
  end

  assign err_irq = |(ev_flags & ev_en);

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_sel))
      SEL_FLAGS:  rd_data = ev_flags;
      SEL_ENABLE: rd_data = ev_en;
      SEL_CODE:   rd_data = {code_acc, code_q};
      SEL_STATUS: rd_data[STAT_AGG] = err_irq;
      default:    rd_data = '0;
    endcase
  end

  // R9: the interrupt needs an enabled, latched flag
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ((ev_flags != '0) && (ev_en != '0)));
  // R2: a bus error pulse always shows up as flag bit 0
  a_r2_buserr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> ev_flags[EV_BUSERR]);
  // R11: a status write leaves the enable mask alone
  a_r11_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STATUS) |=> $stable(ev_en));
endmodule

// File: tb/can_err_report_test.sv
module can_err_report_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_bus_err = 0, ev_overload = 0, ev_overrun = 0, ev_bus_lock = 0;
  logic       ev_busoff_enter = 0, ev_busoff_exit = 0;
  logic [6:0] err_codes = '0;
  logic [7:0] tx_err_cnt = '0, rx_err_cnt = '0;
  logic       wr_en = 0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       err_irq;

  always #5 clk = ~clk;

  can_err_report uut (
    .clk(clk), .rst_n(rst_n), .ev_bus_err(ev_bus_err), .err_codes(err_codes),
    .ev_overload(ev_overload), .ev_overrun(ev_overrun), .ev_bus_lock(ev_bus_lock),
    .ev_busoff_enter(ev_busoff_enter), .ev_busoff_exit(ev_busoff_exit),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .err_irq(err_irq));

  int total = 0, bad = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] m_flags = '0, m_en = '0;
  logic [6:0] m_code = '0;
  logic       m_mode = 1'b0, m_warn_arm = 1'b0, m_pass_arm = 1'b0;

  function automatic logic [7:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_flags;
      2'd1: return m_en;
      2'd2: return {m_mode, m_code};
      default: return ((m_flags & m_en) != 0) ? 8'h20 : 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic warn_now, pass_now;
    logic [7:0] ev;
    logic [6:0] kept;
    if (!rst_n) begin
      m_flags = 0; m_en = 0; m_code = 0; m_mode = 0;
      m_warn_arm = 0; m_pass_arm = 0;
      return;
    end
    warn_now = (tx_err_cnt >= 96) || (rx_err_cnt >= 96);
    pass_now = (tx_err_cnt > 127) || (rx_err_cnt > 127);
    ev = {ev_bus_lock, ev_overload, ev_overrun, ev_busoff_exit, ev_busoff_enter,
          pass_now && !m_pass_arm, warn_now && !m_warn_arm, ev_bus_err};
    m_warn_arm = warn_now;
    m_pass_arm = pass_now;
    kept = (wr_en && wr_sel == 2'd2) ? (m_code & wr_data[6:0]) : m_code;
    if (ev_bus_err) m_code = m_mode ? (kept | err_codes) : err_codes;
    else            m_code = kept;
    if (wr_en && wr_sel == 2'd2) m_mode = wr_data[7];
    if (wr_en && wr_sel == 2'd0) m_flags = m_flags & wr_data;
    m_flags = m_flags | ev;
    if (wr_en && wr_sel == 2'd1) m_en = wr_data;
  endtask

  // inputs are set by the caller at a negative edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, rd_data, m_read(rd_sel));
    check({cur_req, " irq"}, {7'd0, err_irq}, {7'd0, (m_flags & m_en) != 0});
    ev_bus_err = 0; ev_overload = 0; ev_overrun = 0; ev_bus_lock = 0;
    ev_busoff_enter = 0; ev_busoff_exit = 0; wr_en = 0; err_codes = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
  endtask

  initial begin : watchdog
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1: reset values on every register
    cur_req = "R1";
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    for (int s = 0; s < 4; s++) begin rd_sel = 2'(s); tick(); end

    // R2: each event source, read the flag register
    cur_req = "R2"; rd_sel = 0;
    ev_bus_lock = 1; tick();
    ev_overload = 1; tick();
    ev_busoff_enter = 1; tick();
    ev_busoff_exit = 1; tick();
    ev_overrun = 1; tick();
    ev_bus_err = 1; err_codes = 7'h01; tick();
    tick();

    // R3: clear only bits written 0
    cur_req = "R3";
    wr(0, 8'hA5); tick();
    wr(0, 8'hFF); tick();
    wr(0, 8'h00); tick();

    // R4: set and clear collide
    cur_req = "R4";
    ev_overrun = 1; wr(0, 8'h00); tick();
    ev_bus_lock = 1; ev_bus_err = 1; err_codes = 7'h08; wr(0, 8'h00); tick();
    wr(0, 8'h00); tick();

    // R5: warning threshold crossing and re-arm
    cur_req = "R5";
    for (int v = 90; v <= 100; v++) begin tx_err_cnt = 8'(v); tick(); end
    wr(0, 8'h00); tick();
    rx_err_cnt = 8'd110; tick();
    tx_err_cnt = 8'd10; tick();
    rx_err_cnt = 8'd95; tick();
    wr(0, 8'h00); tick();
    rx_err_cnt = 8'd96; tick();
    tick();

    // R6: passive threshold, strictly above 127
    cur_req = "R6";
    wr(0, 8'h00); tick();
    rx_err_cnt = 8'd127; tick();
    rx_err_cnt = 8'd128; tick();
    wr(0, 8'h00); tick();
    tx_err_cnt = 8'd200; rx_err_cnt = 8'd200; tick();
    rx_err_cnt = 8'd20; tx_err_cnt = 8'd20; tick();
    tx_err_cnt = 8'd255; tick();
    tx_err_cnt = 0; rx_err_cnt = 0; wr(0, 8'h00); tick();

    // R7: code capture in replace mode and clear by writing 0
    cur_req = "R7"; rd_sel = 2;
    ev_bus_err = 1; err_codes = 7'h45; tick();
    wr(2, 8'h7B); tick();
    ev_bus_err = 1; err_codes = 7'h12; tick();
    wr(2, 8'h00); tick();

    // R8: accumulate versus replace
    cur_req = "R8";
    wr(2, 8'hFF); tick();
    ev_bus_err = 1; err_codes = 7'h03; tick();
    ev_bus_err = 1; err_codes = 7'h40; tick();
    ev_bus_err = 1; err_codes = 7'h08; wr(2, 8'h80); tick();
    ev_bus_err = 1; err_codes = 7'h20; wr(2, 8'h7F); tick();
    ev_bus_err = 1; err_codes = 7'h04; tick();
    ev_bus_err = 1; err_codes = 7'h10; wr(2, 8'hFF); tick();

    // R10: codes without a bus error pulse
    cur_req = "R10";
    err_codes = 7'h7F; tick();
    err_codes = 7'h2A; tick();

    // R9: enable mask, status bit 5 and interrupt
    cur_req = "R9"; rd_sel = 3;
    wr(0, 8'h00); tick();
    wr(1, 8'h08); tick();
    ev_overload = 1; tick();
    ev_busoff_enter = 1; tick();
    wr(0, 8'hF7); tick();
    wr(1, 8'hFF); tick();
    rd_sel = 1; tick();

    // R11: status writes ignored
    cur_req = "R11";
    rd_sel = 0; ev_bus_lock = 1; tick();
    wr(3, 8'h00); tick();
    rd_sel = 1; wr(3, 8'h00); tick();
    rd_sel = 2; wr(3, 8'h00); tick();

    // randomized mix of all of the above
    cur_req = "R4 mix";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ev_bus_err = r[0] & r[1]; err_codes = r[8:2];
      ev_overload = r[9] & r[10] & r[11];
      ev_overrun = r[12] & r[13] & r[14];
      ev_bus_lock = r[15] & r[16] & r[17];
      ev_busoff_enter = r[18] & r[19] & r[20];
      ev_busoff_exit = r[21] & r[22] & r[23];
      if (r[24] & r[25]) wr(2'(r[27:26]), 8'($urandom));
      if (r[28]) tx_err_cnt = 8'($urandom_range(80, 140));
      if (r[29]) rx_err_cnt = 8'($urandom_range(80, 140));
      rd_sel = r[31:30];
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule